// File: doc/BRIEF.md
# 4x4 Luma Intra Predictor with Shared Filter Terms

This block forms the predicted 4x4 luma block for every one of the nine standard 4x4 intra modes at once, working from the thirteen reconstructed pixels that border the block. Eight of these sit above it (A to H, left to right), four sit to its left (I to L, top to bottom), and one is the corner M. A mode index from the mode-decision logic picks one of the nine candidate blocks, and that block is registered.

Vertical and horizontal prediction copy border pixels. DC prediction averages the four top and four left pixels. The six angular modes are not built from their own filters. They all draw from one pool of 24 filtered terms: thirteen three-tap terms, ten two-tap terms and the raw L pixel. Each term is computed once and then wired to every pixel position and mode that needs it.

Top module: `intra4_pred`

## Requirements
- R1: While `rst_n` is low, `pred_blk` is all zeros.
- R2: `pred_blk` shows the block for the `mode_sel` and border values present at the previous rising clock edge. Changing the inputs between edges does not alter the output until the next edge.
- R3: Mode 0 (vertical) sets pixel [y,x] to the top pixel at column x (A..D) for every row. Pixel [y,x] is at bits (4y+x)*PIX_W of `pred_blk`, and top pixel k is at bits k*PIX_W of `top_nb`.
- R4: Mode 1 (horizontal) sets pixel [y,x] to the left pixel at row y (I..L) for every column. Left pixel y is at bits y*PIX_W of `left_nb`.
- R5: Mode 2 (DC) sets all 16 pixels to (A+B+C+D+I+J+K+L+4)>>3.
- R6: Three-tap terms are (X+2Y+Z+2)>>2 and two-tap terms are (X+Y+1)>>1. The corner terms are (K+3L+2)>>2 and (G+3H+2)>>2. Each term lies between the smallest and the largest of its inputs.
- R7: Mode 3 (diagonal down-left) sets [y,x] to the three-tap term centred on top pixel x+y+1. Position [3,3] uses (G+3H+2)>>2.
- R8: Mode 4 (diagonal down-right) sets [y,x] to the three-tap term centred on the border pixel at offset x-y along the path L..I, M, A..H. Offset 0 is M.
- R9: Mode 5 (vertical-right) follows the standard z=2x-y rule. Even z≥0 gives a two-tap top term, odd z or -1 gives a three-tap term, and z<-1 gives a three-tap left-column term.
- R10: Mode 6 (horizontal-down) follows the standard z=2y-x rule, with the same split by z as R9.
- R11: Mode 7 (vertical-left) uses two-tap top terms on even rows and three-tap top terms on odd rows, shifted by y>>1.
- R12: Mode 8 (horizontal-up) follows the standard z=x+2y rule: two-tap or three-tap left terms for z<5, (K+3L+2)>>2 at z=5, and L for z>5.
- R13: `mode_sel` values 9 to 15 give the DC block.
- R14: With every border pixel at its maximum value, every mode outputs maximum-valued pixels, with no wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| top_nb | input | 8*PIX_W | Top border A..H, A in the low bits |
| left_nb | input | 4*PIX_W | Left border I..L, I in the low bits |
| corner_nb | input | PIX_W | Corner pixel M |
| mode_sel | input | 4 | Mode index 0..8; larger values select DC |
| pred_blk | output | 16*PIX_W | Registered predicted block, pixel [y,x] at (4y+x)*PIX_W |

## Verification
The clocked assertions assume that the border pixels and `mode_sel` change only away from the rising edge. They also assume that the values before each edge are the ones the registered output should reflect one cycle later. The bench meets this by driving every input on the falling edge and holding it through the next rising edge. The filter-bound properties hold for any border values, so the random stimulus can use the full pixel range. It mixes in runs of extreme values (0 and the maximum) so that rounding and carry paths are exercised, and it draws all sixteen `mode_sel` codes, including the out-of-range ones.

// File: rtl/intra4_pkg.sv
package intra4_pkg;
  localparam int unsigned NB_TOTAL = 13;   // L K J I M A B C D E F G H
  localparam int unsigned TAP3_N   = 13;
  localparam int unsigned TAP2_N   = 10;
  localparam int unsigned BLK_PIX  = 16;
  localparam int unsigned MODE_N   = 9;
  localparam int unsigned MODE_W   = 4;

  typedef enum logic [MODE_W-1:0] {
    M_VERT = 4'd0, M_HORZ = 4'd1, M_DC = 4'd2, M_DDL = 4'd3, M_DDR = 4'd4,
    M_VR   = 4'd5, M_HD   = 4'd6, M_VL = 4'd7, M_HU  = 4'd8
  } pred_mode_e;

  // weighted three-tap smoothing with rounding
  function automatic logic [31:0] tap3_f(logic [31:0] a, logic [31:0] b, logic [31:0] c);
    return (a + 2 * b + c + 32'd2) >> 2;
  endfunction

  // two-tap average with rounding
  function automatic logic [31:0] tap2_f(logic [31:0] a, logic [31:0] b);
    return (a + b + 32'd1) >> 1;
  endfunction

  // rounded mean of eight values, given their sum
  function automatic logic [31:0] dc_f(logic [31:0] sum8);
    return (sum8 + 32'd4) >> 3;
  endfunction
endpackage

// File: rtl/intra4_term_pool.sv
module intra4_term_pool
  import intra4_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic [8*PIX_W-1:0]              top_nb,
  input  logic [4*PIX_W-1:0]              left_nb,
  input  logic [PIX_W-1:0]                corner_nb,
  output logic [NB_TOTAL-1:0][PIX_W-1:0]  nb_line,
  output logic [TAP3_N-1:0][PIX_W-1:0]    tap3,
  output logic [TAP2_N-1:0][PIX_W-1:0]    tap2,
  output logic [PIX_W-1:0]                raw_l
);
  // one continuous border path: index 0 = L ... 3 = I, 4 = M, 5 = A ... 12 = H
  for (genvar k = 0; k < 4; k++) begin : g_left
    assign nb_line[k] = left_nb[(3-k)*PIX_W +: PIX_W];
  end
  assign nb_line[4] = corner_nb;
  for (genvar k = 0; k < 8; k++) begin : g_top
    assign nb_line[5+k] = top_nb[k*PIX_W +: PIX_W];
  end

  // three-tap terms centred on each border pixel; the ends replicate
  // their centre, giving K+3L and G+3H
  for (genvar k = 0; k < TAP3_N; k++) begin : g_tap3
    localparam int LO = (k == 0) ? 0 : k - 1;
    localparam int HI = (k == TAP3_N - 1) ? k : k + 1;
    assign tap3[k] = PIX_W'(tap3_f(32'(nb_line[LO]), 32'(nb_line[k]), 32'(nb_line[HI])));
  end

  // two-tap terms between neighbours L/K .. E/F
  for (genvar k = 0; k < TAP2_N; k++) begin : g_tap2
    assign tap2[k] = PIX_W'(tap2_f(32'(nb_line[k]), 32'(nb_line[k+1])));
  end

  assign raw_l = nb_line[0];
endmodule

// File: rtl/intra4_mode_router.sv
module intra4_mode_router
  import intra4_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic [8*PIX_W-1:0]                        top_nb,
  input  logic [4*PIX_W-1:0]                        left_nb,
  input  logic [TAP3_N-1:0][PIX_W-1:0]              tap3,
  input  logic [TAP2_N-1:0][PIX_W-1:0]              tap2,
  input  logic [PIX_W-1:0]                          raw_l,
  output logic [MODE_N-1:0][BLK_PIX-1:0][PIX_W-1:0] mode_blk
);
  localparam int SUM_W = PIX_W + 3;

  logic [SUM_W-1:0] dc_sum;
  logic [PIX_W-1:0] dc_val;

  always_comb begin
    dc_sum = '0;
    for (int i = 0; i < 4; i++) begin
      dc_sum = dc_sum + SUM_W'(top_nb[i*PIX_W +: PIX_W]) + SUM_W'(left_nb[i*PIX_W +: PIX_W]);
    end
  end
  assign dc_val = PIX_W'(dc_f(32'(dc_sum)));

  for (genvar y = 0; y < 4; y++) begin : g_row
    for (genvar x = 0; x < 4; x++) begin : g_col
      localparam int POS = 4*y + x;
      localparam int ZVR = 2*x - y;
      localparam int ZHD = 2*y - x;
      localparam int ZHU = x + 2*y;

      assign mode_blk[M_VERT][POS] = top_nb[x*PIX_W +: PIX_W];
      assign mode_blk[M_HORZ][POS] = left_nb[y*PIX_W +: PIX_W];
      assign mode_blk[M_DC][POS]   = dc_val;
      assign mode_blk[M_DDL][POS]  = tap3[6 + x + y];
      assign mode_blk[M_DDR][POS]  = tap3[4 + x - y];

      if (ZVR >= 0 && (ZVR % 2) == 0) begin : g_vr_a
        assign mode_blk[M_VR][POS] = tap2[4 + x - (y >> 1)];
      end else if (ZVR >= -1) begin : g_vr_b
        assign mode_blk[M_VR][POS] = tap3[4 + x - (y >> 1)];
      end else begin : g_vr_c
        assign mode_blk[M_VR][POS] = tap3[5 - y];
      end

      if (ZHD >= 0 && (ZHD % 2) == 0) begin : g_hd_a
        assign mode_blk[M_HD][POS] = tap2[3 - y + (x >> 1)];
      end else if (ZHD >= -1) begin : g_hd_b
        assign mode_blk[M_HD][POS] = tap3[4 - y + (x >> 1)];
      end else begin : g_hd_c
        assign mode_blk[M_HD][POS] = tap3[3 + x];
      end

      if ((y % 2) == 0) begin : g_vl_a
        assign mode_blk[M_VL][POS] = tap2[5 + x + (y >> 1)];
      end else begin : g_vl_b
        assign mode_blk[M_VL][POS] = tap3[6 + x + (y >> 1)];
      end

      if (ZHU < 5 && (ZHU % 2) == 0) begin : g_hu_a
        assign mode_blk[M_HU][POS] = tap2[2 - y - (x >> 1)];
      end else if (ZHU < 5) begin : g_hu_b
        assign mode_blk[M_HU][POS] = tap3[2 - y - (x >> 1)];
      end else if (ZHU == 5) begin : g_hu_c
        assign mode_blk[M_HU][POS] = tap3[0];
      end else begin : g_hu_d
        assign mode_blk[M_HU][POS] = raw_l;
      end
    end
  end
endmodule

// File: rtl/intra4_pred.sv
module intra4_pred
  import intra4_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [8*PIX_W-1:0]    top_nb,
  input  logic [4*PIX_W-1:0]    left_nb,
  input  logic [PIX_W-1:0]      corner_nb,
  input  logic [MODE_W-1:0]     mode_sel,
  output logic [16*PIX_W-1:0]   pred_blk
);
  logic [NB_TOTAL-1:0][PIX_W-1:0]          nb_line;
  logic [TAP3_N-1:0][PIX_W-1:0]            tap3;
  logic [TAP2_N-1:0][PIX_W-1:0]            tap2;
  logic [PIX_W-1:0]                        raw_l;
  logic [MODE_N-1:0][BLK_PIX-1:0][PIX_W-1:0] mode_blk;
  logic [MODE_W-1:0]                       sel_eff;
  logic                                    sel_oor;
  logic [BLK_PIX-1:0][PIX_W-1:0]           pred_q;

  intra4_term_pool #(.PIX_W(PIX_W)) u_pool (
    .top_nb    (top_nb),
    .left_nb   (left_nb),
    .corner_nb (corner_nb),
    .nb_line   (nb_line),
    .tap3      (tap3),
    .tap2      (tap2),
    .raw_l     (raw_l)
  );

  intra4_mode_router #(.PIX_W(PIX_W)) u_route (
    .top_nb   (top_nb),
    .left_nb  (left_nb),
    .tap3     (tap3),
    .tap2     (tap2),
    .raw_l    (raw_l),
    .mode_blk (mode_blk)
  );

  assign sel_oor = (mode_sel > MODE_W'(MODE_N - 1));
  assign sel_eff = sel_oor ? M_DC : mode_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pred_q <= '0;
    else        pred_q <= mode_blk[sel_eff];
  end

  assign pred_blk = pred_q;

  // ---------------- assertions ----------------
  // R6
  for (genvar k = 0; k < TAP3_N; k++) begin : g_t3_chk
    localparam int LO = (k == 0) ? 0 : k - 1;
    localparam int HI = (k == TAP3_N - 1) ? k : k + 1;
    // R6
    tap3_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tap3[k] <= ((nb_line[LO] > nb_line[k]) ? ((nb_line[LO] > nb_line[HI]) ? nb_line[LO] : nb_line[HI])
                                              : ((nb_line[k]  > nb_line[HI]) ? nb_line[k]  : nb_line[HI])))
      && (tap3[k] >= ((nb_line[LO] < nb_line[k]) ? ((nb_line[LO] < nb_line[HI]) ? nb_line[LO] : nb_line[HI])
                                                 : ((nb_line[k]  < nb_line[HI]) ? nb_line[k]  : nb_line[HI]))));
  end
  for (genvar k = 0; k < TAP2_N; k++) begin : g_t2_chk
    // R6
    tap2_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tap2[k] <= ((nb_line[k] > nb_line[k+1]) ? nb_line[k] : nb_line[k+1]))
      && (tap2[k] >= ((nb_line[k] < nb_line[k+1]) ? nb_line[k] : nb_line[k+1])));
  end

  for (genvar y = 0; y < 4; y++) begin : g_px_chk
    for (genvar x = 0; x < 4; x++) begin : g_px
      // R3
      vert_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_sel) == M_VERT) |-> pred_q[4*y+x] == $past(top_nb[x*PIX_W +: PIX_W]));
      // R4
      horz_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_sel) == M_HORZ) |-> pred_q[4*y+x] == $past(left_nb[y*PIX_W +: PIX_W]));
      // R5
      dc_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_sel) == M_DC) |-> pred_q[4*y+x] == pred_q[0]);
      // R13
      oor_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel_oor) |-> pred_q[4*y+x] == pred_q[0]);
      if (y > 0 && x < 3) begin : g_ddl
        // R7
        ddl_diag_chk: assert property (@(posedge clk) disable iff (!rst_n)
          ($past(mode_sel) == M_DDL) |-> pred_q[4*y+x] == pred_q[4*(y-1)+x+1]);
      end
      if (y > 0 && x > 0) begin : g_ddr
        // R8
        ddr_diag_chk: assert property (@(posedge clk) disable iff (!rst_n)
          ($past(mode_sel) == M_DDR) |-> pred_q[4*y+x] == pred_q[4*(y-1)+x-1]);
      end
    end
  end
endmodule

// File: tb/intra4_pred_test.sv
module intra4_pred_test;
  localparam int PW = 8;
  localparam int PMAX = (1 << PW) - 1;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [8*PW-1:0] top_nb;
  logic [4*PW-1:0] left_nb;
  logic [PW-1:0]   corner_nb;
  logic [3:0]      mode_sel;
  logic [16*PW-1:0] pred_blk;

  int nb_top[8];
  int nb_left[4];
  int nb_m;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int prev_exp[16];

  always #2 clk = ~clk;

  intra4_pred #(.PIX_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .top_nb(top_nb), .left_nb(left_nb),
    .corner_nb(corner_nb), .mode_sel(mode_sel), .pred_blk(pred_blk)
  );

  task automatic drive_nb();
    for (int i = 0; i < 8; i++) top_nb[i*PW +: PW] = PW'(nb_top[i]);
    for (int i = 0; i < 4; i++) left_nb[i*PW +: PW] = PW'(nb_left[i]);
    corner_nb = PW'(nb_m);
  endtask

  // neighbour fetch in standard coordinates: row -1 is above, column -1 is left
  function automatic int nb(int x, int y);
    if (y == -1 && x == -1) return nb_m;
    if (y == -1) return nb_top[x];
    return nb_left[y];
  endfunction

  function automatic int f3(int a, int b, int c);
    return (a + 2*b + c + 2) / 4;
  endfunction

  function automatic int f2(int a, int b);
    return (a + b + 1) / 2;
  endfunction

  function automatic int ref_pix(int md, int x, int y);
    int z;
    int s;
    case (md)
      0: return nb(x, -1);
      1: return nb(-1, y);
      3: begin
        if (x == 3 && y == 3) return (nb(6,-1) + 3*nb(7,-1) + 2) / 4;
        return f3(nb(x+y,-1), nb(x+y+1,-1), nb(x+y+2,-1));
      end
      4: begin
        if (x > y) return f3(nb(x-y-2,-1), nb(x-y-1,-1), nb(x-y,-1));
        if (x < y) return f3(nb(-1,y-x-2), nb(-1,y-x-1), nb(-1,y-x));
        return f3(nb(0,-1), nb(-1,-1), nb(-1,0));
      end
      5: begin
        z = 2*x - y; s = x - y/2;
        if (z >= 0 && z % 2 == 0) return f2(nb(s-1,-1), nb(s,-1));
        if (z > 0) return f3(nb(s-2,-1), nb(s-1,-1), nb(s,-1));
        if (z == -1) return f3(nb(-1,0), nb(-1,-1), nb(0,-1));
        return f3(nb(-1,y-1), nb(-1,y-2), nb(-1,y-3));
      end
      6: begin
        z = 2*y - x; s = y - x/2;
        if (z >= 0 && z % 2 == 0) return f2(nb(-1,s-1), nb(-1,s));
        if (z > 0) return f3(nb(-1,s-2), nb(-1,s-1), nb(-1,s));
        if (z == -1) return f3(nb(-1,0), nb(-1,-1), nb(0,-1));
        return f3(nb(x-1,-1), nb(x-2,-1), nb(x-3,-1));
      end
      7: begin
        s = x + y/2;
        if (y % 2 == 0) return f2(nb(s,-1), nb(s+1,-1));
        return f3(nb(s,-1), nb(s+1,-1), nb(s+2,-1));
      end
      8: begin
        z = x + 2*y; s = y + x/2;
        if (z < 5 && z % 2 == 0) return f2(nb(-1,s), nb(-1,s+1));
        if (z < 5) return f3(nb(-1,s), nb(-1,s+1), nb(-1,s+2));
        if (z == 5) return (nb(-1,2) + 3*nb(-1,3) + 2) / 4;
        return nb(-1,3);
      end
      default: begin
        s = 4;
        for (int i = 0; i < 4; i++) s += nb_top[i] + nb_left[i];
        return s / 8;
      end
    endcase
  endfunction

  function automatic string tag_of(int md);
    case (md)
      0: return "R3";  1: return "R4";  2: return "R5";
      3: return "R7";  4: return "R8";  5: return "R9";
      6: return "R10"; 7: return "R11"; 8: return "R12";
      default: return "R13";
    endcase
  endfunction

  // drive at a falling edge, compare at the next falling edge (one register)
  task automatic apply(input int md, input string tag);
    bit bad;
    int got;
    int exp;
    drive_nb();
    mode_sel = 4'(md);
    @(negedge clk);
    n_vec++;
    bad = 1'b0;
    for (int p = 0; p < 16; p++) begin
      got = int'(pred_blk[p*PW +: PW]);
      exp = ref_pix(md, p % 4, p / 4);
      prev_exp[p] = exp;
      if (!bad && got != exp) begin
        bad = 1'b1;
        $display("FAIL %s mode=%0d pixel[%0d,%0d] actual=%0d expected=%0d", tag, md, p/4, p%4, got, exp);
      end
    end
    if (bad) n_bad++;
  endtask

  task automatic fill(input int t0, input int tstep, input int l0, input int lstep, input int m);
    for (int i = 0; i < 8; i++) nb_top[i] = (t0 + i*tstep) & PMAX;
    for (int i = 0; i < 4; i++) nb_left[i] = (l0 + i*lstep) & PMAX;
    nb_m = m & PMAX;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    bit bad;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    mode_sel = 4'd0;
    fill(37, 19, 201, -23, 90);
    drive_nb();
    repeat (3) @(negedge clk);
    // R1: reset holds the output at zero
    n_vec++;
    if (pred_blk != '0) begin
      n_bad++;
      $display("FAIL R1 reset actual=%h expected=0", pred_blk);
    end
    rst_n = 1'b1;

    // ramp pattern through every mode
    fill(10, 20, 5, 30, 100);
    for (int md = 0; md < 9; md++) apply(md, tag_of(md));
    // descending pattern
    fill(250, -17, 3, 61, 7);
    for (int md = 0; md < 9; md++) apply(md, tag_of(md));

    // R2: inputs changed mid-cycle do not reach the output before the edge
    fill(1, 3, 2, 5, 9);
    drive_nb();
    mode_sel = 4'd2;
    #1;
    n_vec++;
    bad = 1'b0;
    for (int p = 0; p < 16; p++)
      if (!bad && int'(pred_blk[p*PW +: PW]) != prev_exp[p]) begin
        bad = 1'b1;
        $display("FAIL R2 pixel %0d actual=%0d expected=%0d", p, pred_blk[p*PW +: PW], prev_exp[p]);
      end
    if (bad) n_bad++;
    @(negedge clk);
    apply(2, "R2");

    // R6: odd alternating values stress the rounding constants
    fill(1, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) nb_top[i] = (i % 2) ? 2 : 1;
    for (int i = 0; i < 4; i++) nb_left[i] = (i % 2) ? 0 : 3;
    nb_m = 1;
    for (int md = 3; md < 9; md++) apply(md, "R6");

    // R14: all-max border never wraps
    fill(PMAX, 0, PMAX, 0, PMAX);
    for (int md = 0; md < 9; md++) apply(md, "R14");
    // all-zero border
    fill(0, 0, 0, 0, 0);
    apply(4, "R8");
    apply(8, "R12");

    // R13: out-of-range selects
    fill(200, -9, 40, 55, 128);
    apply(9, "R13");
    apply(15, "R13");

    // random stimulus with occasional extreme pixels
    for (int n = 0; n < 1500; n++) begin
      for (int i = 0; i < 8; i++) nb_top[i] = ($urandom_range(0, 7) == 0) ? (($urandom_range(0,1) != 0) ? PMAX : 0) : int'($urandom_range(0, PMAX));
      for (int i = 0; i < 4; i++) nb_left[i] = ($urandom_range(0, 7) == 0) ? (($urandom_range(0,1) != 0) ? PMAX : 0) : int'($urandom_range(0, PMAX));
      nb_m = int'($urandom_range(0, PMAX));
      begin
        int md;
        md = int'($urandom_range(0, 15));
        apply(md, tag_of(md));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule